// File: doc/BRIEF.md
# GPIO Port Register File

This block is the software-visible register set of a general-purpose I/O port with up to 32 pins. A simple word-wide bus reaches an output latch, a direction word and one 32-bit configuration word per pin. The output latch and the direction word each have three write forms: a plain load, a set form that ORs ones in, and a clear form that removes the bits given as ones. Each pin's direction is visible in two places: the packed direction word and bit 0 of that pin's configuration word. A write through either place updates the other.

The current output, direction and configuration values leave the block on flat export buses, which feed a separate pin-resolution stage. That stage returns the resolved input word, and reads of the input offset return it. A bus access is a one-cycle request. Read data and the error flag appear in the cycle after the request and hold until the next request.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output latch and the direction word are 0, and every configuration word reads 0x00000002 on the bus and on the export.
- R2: A write to offset 0x504 replaces the output latch with the write data.
- R3: A write to offset 0x508 ORs the write data into the output latch.
- R4: A write to offset 0x50C clears each output-latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: Writes to the direction word at 0x514 (load), 0x518 (set) and 0x51C (clear) follow the rules of R2 to R4. After any of them, bit 0 of every pin's configuration word equals that pin's new direction bit, and bits 31:1 are unchanged.
- R6: A write to pin n's configuration word at 0x700 + 4*n stores all 32 data bits and loads direction bit n with data bit 0. No other pin is affected.
- R7: A read of 0x504, 0x508 or 0x50C returns the output latch, and a read of 0x514, 0x518 or 0x51C returns the direction word. The data is valid in the cycle after the request.
- R8: A read of 0x700 + 4*n returns pin n's stored configuration word, for each n below the pin count.
- R9: A read of 0x510 returns the resolved input word. A write to 0x510 leaves the output, direction and configuration unchanged.
- R10: An access to any other offset, including an unaligned offset inside the configuration range, raises the error flag in the next cycle. A read there returns 0 and a write there changes no state. Mapped accesses return the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Unmapped-offset flag for the previous request |
| pin_in | input | NUM_PINS (32) | Resolved input word from the pin stage |
| pin_out | output | NUM_PINS (32) | Output latch export |
| pin_dir | output | NUM_PINS (32) | Direction word export |
| pin_cfg | output | NUM_PINS*32 (1024) | Per-pin configuration words, pin n at bits 32n+31:32n |

## Verification
The three write forms are tried with walking-one, alternating and dense arithmetic patterns. These separate a replace from an OR or a masked clear, because each pattern leaves both set and cleared bits in the prior value. The configuration sweep writes a different word to every pin and then reads all of them back. This catches index decoding off by one word and any leakage into neighbouring pins. The direction sweep alternates between writes to the packed word and writes to single configuration words, so a mirror that works in only one direction shows up. Unmapped offsets include addresses just past each range and an unaligned address inside the configuration range.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [11:0] OFF_OUT      = 12'h504;
  localparam logic [11:0] OFF_OUT_SET  = 12'h508;
  localparam logic [11:0] OFF_OUT_CLR  = 12'h50C;
  localparam logic [11:0] OFF_IN       = 12'h510;
  localparam logic [11:0] OFF_DIR      = 12'h514;
  localparam logic [11:0] OFF_DIR_SET  = 12'h518;
  localparam logic [11:0] OFF_DIR_CLR  = 12'h51C;
  localparam logic [11:0] OFF_CFG_BASE = 12'h700;

  localparam logic [31:0] CFG_RESET    = 32'h0000_0002;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_OUT_SET,
    SEL_OUT_CLR,
    SEL_IN,
    SEL_DIR,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_CFG
  } reg_sel_e;

  typedef enum logic [1:0] {
    WOP_LOAD,
    WOP_SET,
    WOP_CLR
  } wop_e;

  function automatic logic [31:0] apply_wop(input logic [31:0] cur,
                                            input logic [31:0] data,
                                            input wop_e        op);
    logic [31:0] res;
    case (op)
      WOP_SET: res = cur | data;
      WOP_CLR: res = cur & ~data;
      default: res = data;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 12,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  cfg_idx
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [ADDR_W-1:0] cfg_off;
  logic [WIDX_W-1:0] word_idx;
  logic              in_cfg;

  always_comb begin
    cfg_off  = addr - ADDR_W'(OFF_CFG_BASE);
    word_idx = cfg_off[ADDR_W-1:2];
    in_cfg   = (addr >= ADDR_W'(OFF_CFG_BASE)) &&
               (word_idx < WIDX_W'(NUM_PINS)) &&
               (cfg_off[1:0] == 2'b00);
    cfg_idx  = word_idx[IDX_W-1:0];
  end

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFF_OUT))          sel = SEL_OUT;
    else if (addr == ADDR_W'(OFF_OUT_SET)) sel = SEL_OUT_SET;
    else if (addr == ADDR_W'(OFF_OUT_CLR)) sel = SEL_OUT_CLR;
    else if (addr == ADDR_W'(OFF_IN))      sel = SEL_IN;
    else if (addr == ADDR_W'(OFF_DIR))     sel = SEL_DIR;
    else if (addr == ADDR_W'(OFF_DIR_SET)) sel = SEL_DIR_SET;
    else if (addr == ADDR_W'(OFF_DIR_CLR)) sel = SEL_DIR_CLR;
    else if (in_cfg)                       sel = SEL_CFG;
  end

endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg
  import gpio_port_pkg::*;
#(
  parameter int          WIDTH = 32,
  parameter logic [31:0] RST   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  wop_e             op,
  input  logic [31:0]      data,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;
  logic [31:0]      q_ext;

  always_comb begin
    q_ext = 32'(q);
    q_d   = q;
    if (en) q_d = WIDTH'(apply_wop(q_ext, data, op));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST[WIDTH-1:0];
    else        q <= q_d;
  end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dir_en,
  input  logic [NUM_PINS-1:0]      dir_val,
  input  logic                     cfg_en,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [31:0]              wdata,
  output logic [NUM_PINS*32-1:0]   cfg_flat,
  output logic [NUM_PINS-1:0]      dir
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic        dir_q, dir_d;
    logic [30:0] hi_q, hi_d;
    logic        hit;

    always_comb begin
      hit   = cfg_en && (cfg_idx == IDX_W'(g));
      dir_d = dir_q;
      hi_d  = hi_q;
      if (hit) begin
        dir_d = wdata[0];
        hi_d  = wdata[31:1];
      end else if (dir_en) begin
        dir_d = dir_val[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= CFG_RESET[0];
        hi_q  <= CFG_RESET[31:1];
      end else begin
        dir_q <= dir_d;
        hi_q  <= hi_d;
      end
    end

    assign cfg_flat[g*32 +: 32] = {hi_q, dir_q};
    assign dir[g]               = dir_q;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_err,
  input  logic [NUM_PINS-1:0]    pin_in,
  output logic [NUM_PINS-1:0]    pin_out,
  output logic [NUM_PINS-1:0]    pin_dir,
  output logic [NUM_PINS*32-1:0] pin_cfg
);

  localparam int IDX_W = $clog2(NUM_PINS);

  reg_sel_e           sel;
  logic [IDX_W-1:0]   cfg_idx;
  logic               wr;
  logic               out_en, dir_en, cfg_en;
  wop_e               out_op, dir_op;
  logic [NUM_PINS-1:0] dir_val;
  logic [31:0]        rd_val;
  logic [31:0]        rdata_d;
  logic               rdata_en;
  logic               err_d;

  gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .sel     (sel),
    .cfg_idx (cfg_idx)
  );

  // write steering
  always_comb begin
    wr     = bus_req && bus_we;
    out_en = 1'b0;
    dir_en = 1'b0;
    cfg_en = 1'b0;
    out_op = WOP_LOAD;
    dir_op = WOP_LOAD;
    case (sel)
      SEL_OUT:     out_en = wr;
      SEL_OUT_SET: begin out_en = wr; out_op = WOP_SET; end
      SEL_OUT_CLR: begin out_en = wr; out_op = WOP_CLR; end
      SEL_DIR:     dir_en = wr;
      SEL_DIR_SET: begin dir_en = wr; dir_op = WOP_SET; end
      SEL_DIR_CLR: begin dir_en = wr; dir_op = WOP_CLR; end
      SEL_CFG:     cfg_en = wr;
      default:     ;
    endcase
    dir_val = NUM_PINS'(apply_wop(32'(pin_dir), bus_wdata, dir_op));
  end

  gpio_mask_reg #(.WIDTH(NUM_PINS), .RST('0)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (out_en),
    .op    (out_op),
    .data  (bus_wdata),
    .q     (pin_out)
  );

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_en   (dir_en),
    .dir_val  (dir_val),
    .cfg_en   (cfg_en),
    .cfg_idx  (cfg_idx),
    .wdata    (bus_wdata),
    .cfg_flat (pin_cfg),
    .dir      (pin_dir)
  );

  // read path
  always_comb begin
    case (sel)
      SEL_OUT, SEL_OUT_SET, SEL_OUT_CLR: rd_val = 32'(pin_out);
      SEL_DIR, SEL_DIR_SET, SEL_DIR_CLR: rd_val = 32'(pin_dir);
      SEL_IN:                            rd_val = 32'(pin_in);
      SEL_CFG:                           rd_val = pin_cfg[cfg_idx*32 +: 32];
      default:                           rd_val = '0;
    endcase
    rdata_en = bus_req && !bus_we;
    rdata_d  = rdata_en ? rd_val : bus_rdata;
    err_d    = bus_req ? (sel == SEL_NONE) : bus_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= err_d;
    end
  end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_req,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic                   bus_err,
  input logic [NUM_PINS-1:0]    pin_out,
  input logic [NUM_PINS-1:0]    pin_dir,
  input logic [NUM_PINS*32-1:0] pin_cfg
);

  logic wr;
  assign wr = bus_req && bus_we;

  p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == ADDR_W'(OFF_OUT_SET) |=>
      ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

  p_out_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == ADDR_W'(OFF_OUT_CLR) |=>
      ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == '0));

  p_in_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == ADDR_W'(OFF_IN) |=>
      $stable(pin_out) && $stable(pin_dir) && $stable(pin_cfg));

  p_err_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(bus_req));

  p_unmapped_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |=> (bus_err -> bus_rdata == '0));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cfgchk
    p_cfg_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr && bus_addr == ADDR_W'(OFF_CFG_BASE) + ADDR_W'(4*g) |=>
        pin_dir[g] == $past(bus_wdata[0]) &&
        pin_cfg[g*32 +: 32] == $past(bus_wdata));
  end

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .pin_out   (pin_out),
  .pin_dir   (pin_dir),
  .pin_cfg   (pin_cfg)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

  localparam int NP = 32;
  localparam logic [11:0] A_OUT = 12'h504, A_OSET = 12'h508, A_OCLR = 12'h50C;
  localparam logic [11:0] A_IN  = 12'h510, A_DIR = 12'h514, A_DSET = 12'h518;
  localparam logic [11:0] A_DCLR = 12'h51C, A_CFG = 12'h700;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_req, bus_we;
  logic [11:0]    bus_addr;
  logic [31:0]    bus_wdata, bus_rdata;
  logic           bus_err;
  logic [NP-1:0]  pin_in, pin_out, pin_dir;
  logic [NP*32-1:0] pin_cfg;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_out, m_dir;
  logic [31:0] m_cfg [NP];

  always #5 clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out),
    .pin_dir(pin_dir), .pin_cfg(pin_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    e = bus_err;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic mirror_dir();
    for (int i = 0; i < NP; i++) m_cfg[i][0] = m_dir[i];
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d; logic e;
    rd(A_OUT, d, e);  chk({tag, " out"}, d, m_out);
    rd(A_DIR, d, e);  chk({tag, " dir"}, d, m_dir);
    chk({tag, " pin_out"}, pin_out, m_out);
    chk({tag, " pin_dir"}, pin_dir, m_dir);
    for (int i = 0; i < NP; i++) begin
      rd(A_CFG + 12'(4*i), d, e);
      chk({tag, " cfg read"}, d, m_cfg[i]);
      chk({tag, " cfg export"}, pin_cfg[i*32 +: 32], m_cfg[i]);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k % 6)
      0: return 32'h1 << (k % 32);
      1: return 32'hAAAA_AAAA;
      2: return 32'h5555_5555;
      3: return 32'(k) * 32'h9E37_79B1;
      4: return ~(32'h1 << ((k * 7) % 32));
      default: return 32'hF0F0_0FF0 ^ (32'(k) << 8);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d; logic e; logic [31:0] p;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    m_out = '0; m_dir = '0;
    for (int i = 0; i < NP; i++) m_cfg[i] = 32'h2;
    check_all("R1");

    // R2 / R7 plain output load and alias reads
    for (int k = 0; k < 12; k++) begin
      p = pat(k);
      wr(A_OUT, p, e); m_out = p;
      chk("R2 pin_out", pin_out, m_out);
      rd(A_OUT, d, e);  chk("R7 read out", d, m_out);
      rd(A_OSET, d, e); chk("R7 read out-set alias", d, m_out);
      rd(A_OCLR, d, e); chk("R7 read out-clr alias", d, m_out);
      chk("R10 no err on mapped read", 32'(e), 32'h0);
    end

    // R3 set, R4 clear
    for (int k = 0; k < 12; k++) begin
      wr(A_OUT, pat(k + 3), e); m_out = pat(k + 3);
      p = pat(k + 1);
      wr(A_OSET, p, e); m_out = m_out | p;
      chk("R3 set", pin_out, m_out);
      p = pat(k + 2);
      wr(A_OCLR, p, e); m_out = m_out & ~p;
      chk("R4 clear", pin_out, m_out);
      rd(A_OUT, d, e); chk("R4 read", d, m_out);
    end

    // R5 direction forms with mirror into configuration bit 0
    for (int k = 0; k < 6; k++) begin
      p = pat(k + 4);
      wr(A_DIR, p, e);  m_dir = p; mirror_dir();
      check_all("R5 dir load");
      p = pat(k + 5);
      wr(A_DSET, p, e); m_dir = m_dir | p; mirror_dir();
      chk("R5 dir set", pin_dir, m_dir);
      rd(A_DSET, d, e); chk("R7 read dir-set alias", d, m_dir);
      p = pat(k + 1);
      wr(A_DCLR, p, e); m_dir = m_dir & ~p; mirror_dir();
      rd(A_DCLR, d, e); chk("R7 read dir-clr alias", d, m_dir);
      check_all("R5 dir clr");
    end

    // R6 / R8 configuration sweep
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NP; i++) begin
        p = (32'(i) * 32'h0101_0F0F) ^ pat(i + k);
        wr(A_CFG + 12'(4*i), p, e);
        m_cfg[i] = p; m_dir[i] = p[0];
        chk("R6 dir bit copy", pin_dir, m_dir);
      end
      check_all("R8 cfg sweep");
    end

    // R9 input read and ignored write
    for (int k = 0; k < 8; k++) begin
      pin_in = pat(k + 2);
      rd(A_IN, d, e); chk("R9 read input", d, pin_in);
    end
    wr(A_IN, 32'hFFFF_FFFF, e);
    chk("R9 input write no err", 32'(e), 32'h0);
    check_all("R9 after input write");

    // R10 unmapped accesses
    begin
      logic [11:0] bad [8];
      bad = '{12'h000, 12'h500, 12'h520, 12'h6FC, 12'h780, 12'h702, 12'h505, 12'hFFC};
      for (int j = 0; j < 8; j++) begin
        rd(bad[j], d, e);
        chk("R10 unmapped read data", d, 32'h0);
        chk("R10 unmapped read err", 32'(e), 32'h1);
        wr(bad[j], 32'hFFFF_FFFF, e);
        chk("R10 unmapped write err", 32'(e), 32'h1);
      end
      check_all("R10 state after unmapped writes");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule